// File: doc/BRIEF.md
# Serial Audio Link Power Manager

This block sits on the codec side of a frame-based serial audio link and owns the link's power state. It runs from a free-running master clock and divides that clock by two to make the bit clock it drives to the controller. While the link is running, it decodes each outgoing command frame from the controller. When a frame writes the power-control register with the halt bit set, the block parks the bit clock low and forces the return data line low.

When the link is halted there is no bit clock, so the controller can wake the link in two ways. A warm wake is a long SYNC pulse. It restarts clocking and keeps the power-control register as it was. A cold wake is the asynchronous RESET pin. It restarts clocking and loads the register default.

SYNC and RESET reach the wake logic only through synchronizers clocked by the master clock. A quiet link, with SYNC and SDOUT both held low, is a normal halted condition. There are no streaming payloads here, so every pin is a plain level.

Top module: `link_power_mgr`

## Requirements
- R1: After cold reset the link state is ACTIVE (code 00) and the power-control register holds its default of 0x0000. While ACTIVE, the bit clock changes level on every master clock.
- R2: When a valid write to register 0x26 has data bit 12 set, the link enters HALTED (code 01). From then on the bit clock and the return data output stay low.
- R3: A command counts only when three conditions hold. Tag bits 15, 14 and 13 must all be 1. Slot 1 bit 19 must be 0, which marks a write. Slot 1 bits 18:12 must equal 0x26. A frame that fails any of these conditions leaves the register and the link state unchanged.
- R4: A frame starts on the first bit for which SYNC is sampled high after being sampled low. SYNC and SDOUT are sampled on the falling bit clock edge. The frame is a 16-bit tag followed by 20-bit slots, sent MSB first. The register write data is slot 2 bits 19:4.
- R5: A valid write to 0x26 with data bit 12 clear updates the register and leaves the link ACTIVE.
- R6: In HALTED, SYNC held high for at least SYNC_MIN master clocks (8 by default) moves the link to WAKING (code 10). The bit clock stays low while WAKING.
- R7: In HALTED, a SYNC pulse shorter than SYNC_MIN is ignored. The link stays HALTED with the bit clock low.
- R8: From WAKING, SYNC falling returns the link to ACTIVE with the register value kept. The restarted bit clock begins low, and its first edge is a rising edge.
- R9: Asserting RESET low in any state moves the link to ACTIVE and loads the register default.
- R10: While ACTIVE, the return data output follows the return data input.
- R11: After a warm wake, a command in the first complete frame is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Free-running master clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset |
| sync_in | input | 1 | Frame sync from the controller; also carries the warm wake request |
| sdout_in | input | 1 | Serial command data from the controller |
| sdatin_in | input | 1 | Return data from the codec's data path |
| bitclk_out | output | 1 | Gated bit clock, running at half the master clock rate |
| sdatin_out | output | 1 | Return data to the controller, forced low unless ACTIVE |
| link_state | output | 2 | 00 ACTIVE, 01 HALTED, 10 WAKING |
| pwr_reg | output | 16 | Current power-control register value |

## Verification
The bench sends frames that each break one decode condition: a missing slot tag, a read command, or a neighbouring register index. If the decoder were too loose, any one of these frames would halt the link or corrupt the register. A SYNC pulse a few clocks shorter than the minimum checks that a glitch cannot wake the link. The bench also watches the first bit clock levels after a warm restart, so a runt pulse or an inverted starting phase would show up. The last checks confirm that a warm wake keeps a register value containing the halt bit, while a cold reset clears it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'b00,
    ST_HALT   = 2'b01,
    ST_WAKE   = 2'b10
  } link_st_e;
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain;
  // Assert at once, release on a clock edge
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end
  assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpm_frame_rx.sv
module lpm_frame_rx #(
  parameter int FRAME_BITS = 256,
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  parameter int TAG_NEED   = 3,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter logic [ADDR_W-1:0] PD_ADDR = 7'h26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample_en,
  input  logic              sync_bit,
  input  logic              data_bit,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data
);
  localparam int IDX_W   = $clog2(FRAME_BITS);
  localparam int SH_W    = 2 * SLOT_BITS;
  localparam int CMD_END = TAG_BITS + SH_W - 1;
  localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] END_I   = IDX_W'(CMD_END);
  localparam logic [IDX_W-1:0] TAG_I   = IDX_W'(TAG_NEED);
  localparam logic [IDX_W-1:0] SLOT0_I = IDX_W'(TAG_BITS);

  logic [IDX_W-1:0] idx, cur;
  logic             sync_prev, in_frame, tag_ok, sync_rise;
  logic [SH_W-1:0]  sh, full;
  logic [SLOT_BITS-1:0] s1, s2;

  assign sync_rise = sync_bit && !sync_prev;
  assign cur  = sync_rise ? '0 : idx;
  assign full = {sh[SH_W-2:0], data_bit};
  assign s1   = full[SH_W-1 -: SLOT_BITS];
  assign s2   = full[SLOT_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      idx <= '0; sync_prev <= 1'b0; in_frame <= 1'b0; tag_ok <= 1'b0;
      sh <= '0; wr_valid <= 1'b0; wr_data <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (sample_en) begin
        sync_prev <= sync_bit;
        if (sync_rise) in_frame <= 1'b1;
        idx <= (cur == LAST_I) ? cur : cur + 1'b1;
        if (in_frame || sync_rise) begin
          if (cur == '0)        tag_ok <= data_bit;
          else if (cur < TAG_I) tag_ok <= tag_ok & data_bit;
          if (cur >= SLOT0_I && cur <= END_I) sh <= full;
          if (cur == END_I && tag_ok && !s1[SLOT_BITS-1]
              && s1[SLOT_BITS-2 -: ADDR_W] == PD_ADDR) begin
            wr_valid <= 1'b1;
            wr_data  <= s2[SLOT_BITS-1 -: DATA_W];
          end
        end
      end
    end
  end

  // A write strobe only follows a bit sample
  assert_wr_after_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(sample_en));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PD_BIT   = 12,
  parameter int SYNC_MIN = 8,
  parameter logic [DATA_W-1:0] PD_DEFAULT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_s,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              bitclk,
  output logic              sample_en,
  output logic              active,
  output link_st_e          state,
  output logic [DATA_W-1:0] pd_reg
);
  localparam int CW = $clog2(SYNC_MIN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SYNC_MIN - 1);

  logic [CW-1:0] cnt;
  logic          halt_req;

  assign active    = (state == ST_ACTIVE);
  assign halt_req  = active && wr_valid && wr_data[PD_BIT];
  assign sample_en = active && bitclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_ACTIVE;
      bitclk <= 1'b0;
      cnt    <= '0;
      pd_reg <= PD_DEFAULT;
    end else begin
      bitclk <= (active && !halt_req) ? ~bitclk : 1'b0;
      if (wr_valid) pd_reg <= wr_data;
      unique case (state)
        ST_ACTIVE: begin
          cnt <= '0;
          if (halt_req) state <= ST_HALT;
        end
        ST_HALT: begin
          if (!sync_s)              cnt <= '0;
          else if (cnt == CNT_LAST) begin cnt <= '0; state <= ST_WAKE; end
          else                      cnt <= cnt + 1'b1;
        end
        ST_WAKE: if (!sync_s) state <= ST_ACTIVE;
        default: state <= ST_ACTIVE;
      endcase
    end
  end

  assert_halt_on_pd_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_valid && wr_data[PD_BIT]) |=> (state == ST_HALT && !bitclk));
  assert_halt_not_direct_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |=> (state != ST_ACTIVE));
  assert_reg_kept_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_ACTIVE) |=> $stable(pd_reg));
  assert_wake_needs_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !sync_s) |=> (state == ST_HALT));
  assert_no_clock_off_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_ACTIVE) |-> !bitclk);
endmodule

// File: rtl/link_power_mgr.sv
module link_power_mgr
  import lpm_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  parameter int DATA_W     = 16,
  parameter int PD_BIT     = 12,
  parameter int SYNC_MIN   = 8,
  parameter int SYNC_STG   = 2,
  parameter logic [6:0]        PD_ADDR    = 7'h26,
  parameter logic [DATA_W-1:0] PD_DEFAULT = '0
) (
  input  logic              mclk,
  input  logic              cold_rst_n,
  input  logic              sync_in,
  input  logic              sdout_in,
  input  logic              sdatin_in,
  output logic              bitclk_out,
  output logic              sdatin_out,
  output logic [1:0]        link_state,
  output logic [DATA_W-1:0] pwr_reg
);
  logic              rst_n, sync_s, sample_en, active, wr_valid;
  logic [DATA_W-1:0] wr_data;
  link_st_e          state;

  lpm_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(mclk), .arst_n(cold_rst_n), .rst_n(rst_n));

  lpm_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(mclk), .rst_n(rst_n), .d(sync_in), .q(sync_s));

  lpm_frame_rx #(
    .FRAME_BITS(FRAME_BITS), .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS),
    .TAG_NEED(3), .ADDR_W(7), .DATA_W(DATA_W), .PD_ADDR(PD_ADDR)
  ) u_rx (
    .clk(mclk), .rst_n(rst_n), .clear(!active), .sample_en(sample_en),
    .sync_bit(sync_in), .data_bit(sdout_in),
    .wr_valid(wr_valid), .wr_data(wr_data));

  lpm_ctrl #(
    .DATA_W(DATA_W), .PD_BIT(PD_BIT), .SYNC_MIN(SYNC_MIN), .PD_DEFAULT(PD_DEFAULT)
  ) u_ctrl (
    .clk(mclk), .rst_n(rst_n), .sync_s(sync_s), .wr_valid(wr_valid),
    .wr_data(wr_data), .bitclk(bitclk_out), .sample_en(sample_en),
    .active(active), .state(state), .pd_reg(pwr_reg));

  assign sdatin_out = active & sdatin_in;
  assign link_state = state;

  assert_return_low_idle_R10: assert property (@(posedge mclk) disable iff (!rst_n)
    (link_state != 2'b00) |-> !sdatin_out);
endmodule

// File: tb/link_power_mgr_tb.sv
module link_power_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_MIN   = 8;

  logic mclk = 1'b0, cold_rst_n = 1'b0, sync_in = 1'b0, sdout_in = 1'b0, sdatin_in = 1'b0;
  logic bitclk_out, sdatin_out;
  logic [1:0]  link_state;
  logic [15:0] pwr_reg;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) mclk = ~mclk;

  link_power_mgr u_dut (
    .mclk(mclk), .cold_rst_n(cold_rst_n), .sync_in(sync_in), .sdout_in(sdout_in),
    .sdatin_in(sdatin_in), .bitclk_out(bitclk_out), .sdatin_out(sdatin_out),
    .link_state(link_state), .pwr_reg(pwr_reg));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge mclk);
  endtask

  // Drive one frame, one bit per bit clock rise; stop if the link leaves ACTIVE
  task automatic send_frame(input logic [15:0] tag, input logic [19:0] s1, input logic [19:0] s2);
    logic [255:0] bits;
    logic prev, rise;
    bits = {tag, s1, s2, 200'b0};
    prev = bitclk_out;
    for (int i = 0; i < 256; i++) begin
      if (link_state != 2'b00) break;
      forever begin
        @(negedge mclk);
        rise = bitclk_out && !prev;
        prev = bitclk_out;
        if (rise || link_state != 2'b00) break;
      end
      if (link_state != 2'b00) break;
      sync_in  = (i < 16);
      sdout_in = bits[255-i];
    end
    idle(2);
    sync_in = 1'b0; sdout_in = 1'b0;
    idle(4);
  endtask

  task automatic write_reg(input logic [6:0] addr, input logic [15:0] data);
    send_frame(16'hE000, {1'b0, addr, 12'h000}, {data, 4'h0});
  endtask

  task automatic wait_active(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (link_state == 2'b00) break;
      @(negedge mclk);
    end
  endtask

  task automatic t_reset;
    logic a, b;
    idle(1); a = bitclk_out; idle(1); b = bitclk_out;
    check(link_state == 2'b00, "R1 state", link_state, 0);
    check(pwr_reg == 16'h0000, "R1 reg", pwr_reg, 0);
    check(a != b, "R1 bitclk toggles", b, !a);
    sdatin_in = 1'b1; #1;
    check(sdatin_out == 1'b1, "R10 return data follows", sdatin_out, 1);
    sdatin_in = 1'b0; #1;
    check(sdatin_out == 1'b0, "R10 return data follows low", sdatin_out, 0);
  endtask

  task automatic t_rejects;
    send_frame(16'hC000, {1'b0, 7'h26, 12'h0}, {16'h1000, 4'h0});
    check(link_state == 2'b00 && pwr_reg == 16'h0, "R3 missing slot2 tag", pwr_reg, 0);
    send_frame(16'hE000, {1'b1, 7'h26, 12'h0}, {16'h1000, 4'h0});
    check(link_state == 2'b00 && pwr_reg == 16'h0, "R3 read command", pwr_reg, 0);
    write_reg(7'h24, 16'h1000);
    check(link_state == 2'b00 && pwr_reg == 16'h0, "R3 other index", pwr_reg, 0);
  endtask

  task automatic t_write_no_halt;
    write_reg(7'h26, 16'h0300);
    check(pwr_reg == 16'h0300, "R5 R4 reg written", pwr_reg, 16'h0300);
    check(link_state == 2'b00, "R5 still active", link_state, 0);
  endtask

  task automatic t_halt(input logic [15:0] data);
    bit low_ok;
    write_reg(7'h26, data);
    check(link_state == 2'b01, "R2 halted", link_state, 1);
    check(pwr_reg == data, "R2 reg", pwr_reg, data);
    sdatin_in = 1'b1;
    low_ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge mclk);
      if (bitclk_out || sdatin_out) low_ok = 1'b0;
    end
    check(low_ok, "R2 clock and return data low", bitclk_out, 0);
    sdatin_in = 1'b0;
  endtask

  task automatic t_short_sync;
    sync_in = 1'b1; idle(SYNC_MIN - 3); sync_in = 1'b0; idle(12);
    check(link_state == 2'b01, "R7 short pulse ignored", link_state, 1);
    check(bitclk_out == 1'b0, "R7 clock stays low", bitclk_out, 0);
  endtask

  task automatic t_warm(input logic [15:0] kept);
    logic [3:0] seq;
    sync_in = 1'b1; idle(SYNC_MIN + 6);
    check(link_state == 2'b10, "R6 waking", link_state, 2);
    check(bitclk_out == 1'b0, "R6 clock low while waking", bitclk_out, 0);
    sync_in = 1'b0;
    wait_active(20);
    check(link_state == 2'b00, "R8 active again", link_state, 0);
    for (int i = 0; i < 4; i++) begin
      seq[3-i] = bitclk_out;
      @(negedge mclk);
    end
    check(seq == 4'b0101, "R8 clean restart phase", seq, 4'b0101);
    check(pwr_reg == kept, "R8 register kept", pwr_reg, kept);
  endtask

  task automatic t_first_frame;
    write_reg(7'h26, 16'h0055);
    check(pwr_reg == 16'h0055, "R11 first frame decoded", pwr_reg, 16'h0055);
  endtask

  task automatic t_cold;
    cold_rst_n = 1'b0; idle(3);
    check(link_state == 2'b00, "R9 active in reset", link_state, 0);
    cold_rst_n = 1'b1; idle(4);
    check(pwr_reg == 16'h0000, "R9 register default", pwr_reg, 0);
    check(link_state == 2'b00, "R9 active after reset", link_state, 0);
  endtask

  initial begin
    idle(3); cold_rst_n = 1'b1; idle(3);
    t_reset();
    t_rejects();
    t_write_no_halt();
    t_halt(16'h1000);
    t_short_sync();
    t_warm(16'h1000);
    t_first_frame();
    t_halt(16'h1F00);
    t_cold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mclk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=0x1 expected=0x0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule